// File: doc/BRIEF.md
# Data Page Translator with Swappable Page-Register Location

This block turns a 16-bit CPU data address into a 22-bit physical address. The two top address bits pick one of four 8-bit page registers. That register supplies physical bits 21:14, and the low 14 address bits pass through unchanged as the offset within a 16-Kbyte page. The four registers together give the CPU a 64-Kbyte window that software can place anywhere in a 4-Mbyte space. Interrupt code and main code use the same window, so the translation does not depend on the interrupt mode.

The page registers are also registers in the CPU's register file, and the block decodes the register-file accesses that reach them. By default they sit in the paged window of the extended register page 21. A single remap input swaps them with the data registers of I/O ports 0 to 3. Those port registers normally live in the unpaged group at addresses 0xE0 to 0xE3. After the swap, software reaches the page registers without saving, setting and restoring the register page pointer, and the port data registers move into page 21. The remap input is expected to come from bit 5 of the extended mode register at address 246 (0xF6) of page 21. The block raises a select for that register so it can be located. Port logic and memories lie outside the block.

Top module: `dpage_xlate`

## Requirements
- R1: After synchronous reset, page register n holds n (n = 0..3), so `phys_addr` equals `cpu_addr` zero-extended to 22 bits.
- R2: `phys_addr[21:14]` is the page register indexed by `cpu_addr[15:14]`, and `phys_addr[13:0]` equals `cpu_addr[13:0]`. The output is combinational from the address and the current register contents.
- R3: With `remap` low, `pg_sel[n]` is raised for an access at page 21, address 0xF0+n. `port_sel[n]` is raised for an access at address 0xE0+n with any page pointer value.
- R4: With `remap` high, `pg_sel[n]` is raised for an access at address 0xE0+n with any page pointer value. `port_sel[n]` is raised for an access at page 21, address 0xF0+n.
- R5: A select line is raised only while `rf_rd` or `rf_wr` is high. At most one bit across `pg_sel`, `port_sel` and `mode_sel` is high at any time. Addresses outside the decoded locations raise none.
- R6: When `rf_wr` is high and `pg_sel[n]` is high, page register n takes `rf_wdata` at the next clock edge. Every other page register keeps its value, and a write that selects no page register changes none of them.
- R7: `rd_data` equals page register n when `rf_rd` and `pg_sel[n]` are both high, and is 0 otherwise. A read in the same cycle as a write returns the old value.
- R8: `mode_sel` is raised for an access at page 21, address 0xF6, whatever the level of `remap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU data address |
| phys_addr | output | 22 | Translated physical address |
| rf_page | input | 8 | Register-file page pointer |
| rf_addr | input | 8 | Register-file address |
| rf_rd | input | 1 | Register read strobe |
| rf_wr | input | 1 | Register write strobe |
| rf_wdata | input | 8 | Register write data |
| remap | input | 1 | Swap page registers with port 0..3 data registers |
| rd_data | output | 8 | Read data from the selected page register, else 0 |
| pg_sel | output | 4 | One-hot select of the page register accessed |
| port_sel | output | 4 | One-hot select of the port 0..3 data register accessed |
| mode_sel | output | 1 | Select of the extended mode register |

## Verification
A corrupted page register shows up in the same cycle in the upper bits of `phys_addr`, for every CPU address in that register's quarter. It also shows up on `rd_data` when the register is read. A wrong decode after a `remap` change appears at once on the select lines, and one cycle later as a page register that was written when it should not have been. The bench's reference model tracks every register and compares all outputs on every clock, so any such divergence is caught in the cycle it first becomes visible.

// File: rtl/dpage_pkg.sv
package dpage_pkg;

    localparam int ADDR_W = 16;
    localparam int OFS_W  = 14;
    localparam int PG_W   = 8;
    localparam int RF_W   = 8;
    localparam int SEL_W  = ADDR_W - OFS_W;
    localparam int NPG    = 1 << SEL_W;
    localparam int PHYS_W = OFS_W + PG_W;
    localparam int IDX_W  = $clog2(NPG);

    typedef logic [PG_W-1:0]          page_t;
    typedef logic [NPG-1:0][PG_W-1:0] page_bank_t;

    typedef struct packed {
        logic [NPG-1:0] pg;
        logic [NPG-1:0] port;
        logic           mode;
    } rf_sel_t;

    // Reset contents: register n maps quarter n onto physical page n.
    function automatic page_t page_reset(input int n);
        return page_t'(n);
    endfunction

endpackage

// File: rtl/dpage_decode.sv
module dpage_decode
    import dpage_pkg::*;
#(
    parameter logic [RF_W-1:0] EXT_PAGE   = 8'd21,
    parameter logic [RF_W-1:0] PAGED_BASE = 8'hF0,
    parameter logic [RF_W-1:0] FIXED_BASE = 8'hE0,
    parameter logic [RF_W-1:0] MODE_ADDR  = 8'hF6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RF_W-1:0] rf_page,
    input  logic [RF_W-1:0] rf_addr,
    input  logic            rf_rd,
    input  logic            rf_wr,
    input  logic            remap,
    output rf_sel_t         sel
);

    logic           access;
    logic           on_ext;
    logic           paged_hit;
    logic           fixed_hit;
    logic [NPG-1:0] onehot;

    always_comb begin
        access    = rf_rd | rf_wr;
        on_ext    = (rf_page == EXT_PAGE);
        paged_hit = on_ext && (rf_addr[RF_W-1:IDX_W] == PAGED_BASE[RF_W-1:IDX_W]);
        fixed_hit = (rf_addr[RF_W-1:IDX_W] == FIXED_BASE[RF_W-1:IDX_W]);
        onehot    = NPG'(1) << rf_addr[IDX_W-1:0];

        sel = '0;
        if (access) begin
            // The remap bit decides which group owns which location.
            if (remap ? fixed_hit : paged_hit) sel.pg   = onehot;
            if (remap ? paged_hit : fixed_hit) sel.port = onehot;
            sel.mode = on_ext && (rf_addr == MODE_ADDR);
        end
    end

    assert_sel_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.pg, sel.port, sel.mode}));

    assert_sel_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !(rf_rd || rf_wr) |-> (sel == '0));

    assert_pg_home_R3: assert property (@(posedge clk) disable iff (rst)
        (!remap && sel.pg != '0) |-> (rf_page == EXT_PAGE));

    assert_port_home_R4: assert property (@(posedge clk) disable iff (rst)
        (remap && sel.port != '0) |-> (rf_page == EXT_PAGE));

endmodule

// File: rtl/dpage_bank.sv
module dpage_bank
    import dpage_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NPG-1:0] we,
    input  logic [NPG-1:0] re,
    input  page_t          wdata,
    output page_bank_t     pages,
    output page_t          rdata
);

    for (genvar i = 0; i < NPG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)       pages[i] <= page_reset(i);
            else if (we[i]) pages[i] <= wdata;
        end

        assert_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
            we[i] |=> (pages[i] == $past(wdata)));

        assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
            !we[i] |=> $stable(pages[i]));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NPG; i++) begin
            if (re[i]) rdata = rdata | pages[i];
        end
    end

endmodule

// File: rtl/dpage_map.sv
module dpage_map
    import dpage_pkg::*;
(
    input  logic [ADDR_W-1:0] cpu_addr,
    input  page_bank_t        pages,
    output logic [PHYS_W-1:0] phys_addr
);

    logic [SEL_W-1:0] quarter;

    always_comb begin
        quarter   = cpu_addr[ADDR_W-1:OFS_W];
        phys_addr = {pages[quarter], cpu_addr[OFS_W-1:0]};
    end

endmodule

// File: rtl/dpage_xlate.sv
module dpage_xlate
    import dpage_pkg::*;
#(
    parameter logic [RF_W-1:0] EXT_PAGE   = 8'd21,
    parameter logic [RF_W-1:0] PAGED_BASE = 8'hF0,
    parameter logic [RF_W-1:0] FIXED_BASE = 8'hE0,
    parameter logic [RF_W-1:0] MODE_ADDR  = 8'hF6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [PHYS_W-1:0] phys_addr,
    input  logic [RF_W-1:0]   rf_page,
    input  logic [RF_W-1:0]   rf_addr,
    input  logic              rf_rd,
    input  logic              rf_wr,
    input  logic [PG_W-1:0]   rf_wdata,
    input  logic              remap,
    output logic [PG_W-1:0]   rd_data,
    output logic [NPG-1:0]    pg_sel,
    output logic [NPG-1:0]    port_sel,
    output logic              mode_sel
);

    rf_sel_t        sel;
    page_bank_t     pages;
    logic [NPG-1:0] we;
    logic [NPG-1:0] re;

    dpage_decode #(
        .EXT_PAGE   (EXT_PAGE),
        .PAGED_BASE (PAGED_BASE),
        .FIXED_BASE (FIXED_BASE),
        .MODE_ADDR  (MODE_ADDR)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .rf_page (rf_page),
        .rf_addr (rf_addr),
        .rf_rd   (rf_rd),
        .rf_wr   (rf_wr),
        .remap   (remap),
        .sel     (sel)
    );

    assign we = sel.pg & {NPG{rf_wr}};
    assign re = sel.pg & {NPG{rf_rd}};

    dpage_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .re    (re),
        .wdata (rf_wdata),
        .pages (pages),
        .rdata (rd_data)
    );

    dpage_map u_map (
        .cpu_addr  (cpu_addr),
        .pages     (pages),
        .phys_addr (phys_addr)
    );

    assign pg_sel   = sel.pg;
    assign port_sel = sel.port;
    assign mode_sel = sel.mode;

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);

    assert_rd_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!rf_rd || pg_sel == '0) |-> (rd_data == '0));

    assert_stable_map_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rf_wr) && $stable(cpu_addr)) |-> $stable(phys_addr));

endmodule

// File: tb/dpage_xlate_bench.sv
module dpage_xlate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [21:0] phys_addr;
    logic [7:0]  rf_page = '0;
    logic [7:0]  rf_addr = '0;
    logic        rf_rd = 1'b0;
    logic        rf_wr = 1'b0;
    logic [7:0]  rf_wdata = '0;
    logic        remap = 1'b0;
    logic [7:0]  rd_data;
    logic [3:0]  pg_sel;
    logic [3:0]  port_sel;
    logic        mode_sel;

    int n_checks = 0;
    int n_errors = 0;
    int mdl [4];
    bit finished = 0;

    always #10 clk = ~clk;

    dpage_xlate u_dpage_xlate (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
        .rf_page(rf_page), .rf_addr(rf_addr), .rf_rd(rf_rd), .rf_wr(rf_wr),
        .rf_wdata(rf_wdata), .remap(remap), .rd_data(rd_data),
        .pg_sel(pg_sel), .port_sel(port_sel), .mode_sel(mode_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_pg();
        int r = 0;
        if (rf_rd || rf_wr) begin
            if (!remap && rf_page == 21 && rf_addr >= 8'hF0 && rf_addr <= 8'hF3)
                r = 1 << (rf_addr - 8'hF0);
            if (remap && rf_addr >= 8'hE0 && rf_addr <= 8'hE3)
                r = 1 << (rf_addr - 8'hE0);
        end
        return r;
    endfunction

    function automatic int exp_port();
        int r = 0;
        if (rf_rd || rf_wr) begin
            if (remap && rf_page == 21 && rf_addr >= 8'hF0 && rf_addr <= 8'hF3)
                r = 1 << (rf_addr - 8'hF0);
            if (!remap && rf_addr >= 8'hE0 && rf_addr <= 8'hE3)
                r = 1 << (rf_addr - 8'hE0);
        end
        return r;
    endfunction

    function automatic int sel_idx(input int oh);
        for (int i = 0; i < 4; i++) if (oh == (1 << i)) return i;
        return -1;
    endfunction

    // Compare all outputs with the model for the inputs now applied.
    task automatic compare_all(input string ptag);
        int ep = exp_pg();
        int eo = exp_port();
        int em = ((rf_rd || rf_wr) && rf_page == 21 && rf_addr == 8'hF6) ? 1 : 0;
        int er = (rf_rd && ep != 0) ? mdl[sel_idx(ep)] : 0;
        int ea = mdl[cpu_addr[15:14]] * 16384 + int'(cpu_addr[13:0]);
        chk({ptag, " phys"}, 32'(phys_addr), 32'(ea));
        chk(remap ? "R4 pg_sel" : "R3 pg_sel", 32'(pg_sel), 32'(ep));
        chk(remap ? "R4 port_sel" : "R3 port_sel", 32'(port_sel), 32'(eo));
        chk("R8 mode_sel", 32'(mode_sel), 32'(em));
        chk("R7 rd_data", 32'(rd_data), 32'(er));
        chk("R5 exclusive", 32'($countones({pg_sel, port_sel, mode_sel}) <= 1), 32'd1);
    endtask

    // Apply inputs at the falling edge, compare, then let one rising edge pass.
    task automatic cyc(input string ptag, input logic [15:0] ca, input logic [7:0] pg,
                       input logic [7:0] ad, input logic rd, input logic wr,
                       input logic [7:0] wd, input logic rm);
        int ep;
        cpu_addr = ca; rf_page = pg; rf_addr = ad; rf_rd = rd; rf_wr = wr;
        rf_wdata = wd; remap = rm;
        #2;
        compare_all(ptag);
        ep = exp_pg();
        @(posedge clk);
        if (wr && ep != 0) mdl[sel_idx(ep)] = int'(wd);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: identity mapping after reset over every quarter
        for (int q = 0; q < 4; q++) begin
            logic [15:0] a = 16'(q * 16384 + 16'h1234);
            cyc("R1", a, 8'd0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);
        end
        cyc("R1", 16'hFFFF, 8'd0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);

        // R3/R6: write page registers at their home location
        for (int i = 0; i < 4; i++)
            cyc("R6", 16'h0000, 8'd21, 8'(8'hF0 + i), 1'b0, 1'b1, 8'(8'hA0 + 17 * i), 1'b0);
        // R2: translation with the new contents
        for (int q = 0; q < 4; q++)
            cyc("R2", 16'(q * 16384 + 16'h3FFF), 8'd0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);
        // R7: reads at home location
        for (int i = 0; i < 4; i++)
            cyc("R7", 16'h8000, 8'd21, 8'(8'hF0 + i), 1'b1, 1'b0, 8'd0, 1'b0);

        // R6: writes that miss, wrong page and port locations, leave pages intact
        cyc("R6", 16'h4000, 8'd20, 8'hF1, 1'b0, 1'b1, 8'h55, 1'b0);
        cyc("R6", 16'h4000, 8'd21, 8'hE1, 1'b0, 1'b1, 8'h66, 1'b0);
        cyc("R6", 16'h4000, 8'd21, 8'hF6, 1'b0, 1'b1, 8'h77, 1'b0);
        cyc("R6", 16'h4000, 8'd0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);

        // R4: swap, reach page registers through the unpaged group from any page
        for (int i = 0; i < 4; i++)
            cyc("R4", 16'hC000, 8'(i * 50), 8'(8'hE0 + i), 1'b0, 1'b1, 8'(8'h10 + i), 1'b1);
        for (int i = 0; i < 4; i++)
            cyc("R4", 16'(i * 16384), 8'd7, 8'(8'hE0 + i), 1'b1, 1'b0, 8'd0, 1'b1);
        // R4: port registers now at page 21; writing them leaves pages alone
        for (int i = 0; i < 4; i++)
            cyc("R4", 16'h4321, 8'd21, 8'(8'hF0 + i), 1'b0, 1'b1, 8'hEE, 1'b1);
        // R8: mode register reachable in both settings
        cyc("R8", 16'h0000, 8'd21, 8'hF6, 1'b1, 1'b0, 8'd0, 1'b1);
        cyc("R8", 16'h0000, 8'd21, 8'hF6, 1'b1, 1'b0, 8'd0, 1'b0);
        // R7: simultaneous read and write returns the old value
        cyc("R7", 16'h0000, 8'd21, 8'hF2, 1'b1, 1'b1, 8'h9C, 1'b0);
        cyc("R7", 16'h8000, 8'd21, 8'hF2, 1'b1, 1'b0, 8'd0, 1'b0);

        // Mixed traffic
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] ad;
            logic [7:0] pg;
            int k = $urandom_range(0, 9);
            if (k < 4)      ad = 8'(8'hE0 + $urandom_range(0, 5));
            else if (k < 8) ad = 8'(8'hF0 + $urandom_range(0, 7));
            else            ad = 8'($urandom);
            pg = ($urandom_range(0, 2) != 0) ? 8'd21 : 8'($urandom);
            cyc("R2", 16'($urandom), pg, ad, 1'($urandom), 1'($urandom),
                8'($urandom), ((n / 64) % 2) == 1);
        end

        // R1: reset again restores identity
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 4; i++) mdl[i] = i;
        @(negedge clk);
        rst = 1'b0;
        cyc("R1", 16'hBEEF, 8'd0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);
        cyc("R1", 16'h7001, 8'd0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule